// File: doc/BRIEF.md
# Bus Release and Refresh Arbiter

This block decides who owns the external memory bus at each cycle boundary: the host's bus sequencer, an external master, or a DRAM refresh. A refresh timer raises requests. An external master asks for the bus with a request line and receives an acknowledge. The host sequencer reports three things: whether it has a cycle in flight, when that cycle completes, and whether the boundary it is crossing sits inside a sequence that must not be broken. There are four such sequences:
- a wide access split over a narrow bus,
- a 32-byte burst,
- the read and write halves of an atomic test-and-set,
- the two phases of a dual-address DMA move.

A refresh that cannot run yet is remembered until it can. If the bus has been lent out, a pending refresh pulls it back: the arbiter drops its acknowledge and waits for the external master to withdraw its request. In row-held (RAS-down) mode, a one-cycle precharge-all strobe comes before every refresh and before every hand-over. Precharge length and refresh length are parameters counted in clocks.

Top module: `busrel_refresh_arb`

## Requirements
- R1: A boundary is either a clock in which no host cycle is in flight, or the clock in which `cyc_done` is high. When a refresh is pending at a boundary and no hold flag is high, `rfsh_start` pulses high for exactly one clock, in the clock after that boundary (with `ras_down` low).
- R2: While `split_hold` is high at a boundary, no refresh starts there.
- R3: While `burst_hold` is high at a boundary, no refresh starts there.
- R4: While `atomic_hold` or `dual_hold` is high at a boundary, no refresh starts there.
- R5: While the bus is lent out, a pending refresh does not start. Instead `bus_ack` drops in the clock after the refresh is seen. The arbiter then waits for `ext_breq` to fall, and `rfsh_start` pulses two clocks after the clock in which `ext_breq` is sampled low.
- R6: With `ras_down` high, `pall_cmd` pulses for one clock at the decision point. `rfsh_start` or the rise of `bus_ack` follows PRE_CYC clocks after that pulse. The two strobes are never high together.
- R7: `bus_ack` rises only in the clock after a free boundary at which `ext_breq` is high. It falls in the clock after `ext_breq` is sampled low.
- R8: When a refresh and an external request are both present at the same free boundary, the refresh runs first. The grant then follows once the refresh has finished and the arbiter has passed through its idle state.
- R9: A refresh request that arrives while no boundary is available is held. Several requests that arrive before service produce one refresh only.
- R10: While `rst` is high, `bus_ack`, `rfsh_start` and `pall_cmd` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ras_down | input | 1 | Row-held mode: precharge before refresh and before hand-over |
| host_cyc | input | 1 | Host sequencer has a bus cycle in flight or waiting |
| cyc_done | input | 1 | Current host bus cycle completes this clock |
| split_hold | input | 1 | Narrow-bus split access continues past this boundary |
| burst_hold | input | 1 | 32-byte burst continues past this boundary |
| atomic_hold | input | 1 | Between read and write of a test-and-set |
| dual_hold | input | 1 | Between phases of a dual-address DMA transfer |
| rfsh_req | input | 1 | Refresh request from the interval timer |
| ext_breq | input | 1 | Bus request from the external master |
| bus_ack | output | 1 | Bus granted to the external master |
| rfsh_start | output | 1 | One-clock refresh start strobe |
| pall_cmd | output | 1 | One-clock precharge-all command strobe |

## Verification
The bench builds the arbiter with PRE_CYC=3 and REF_CYC=2. Because the two lengths differ, a swapped or off-by-one phase count moves the refresh strobe or the grant to a different clock, and the scoreboard reports the wrong cycle. With both phases this short, every deferral, reclaim and precharge sequence can be checked at exact clock positions within a few dozen cycles.

// File: rtl/busrel_pkg.sv
package busrel_pkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_HOST     = 3'd1,
    ST_PRECHG   = 3'd2,
    ST_REFRESH  = 3'd3,
    ST_RELEASED = 3'd4,
    ST_RECLAIM  = 3'd5
  } arb_state_e;

  localparam int unsigned NUM_HOLD = 4;

endpackage

// File: rtl/busrel_hold_merge.sv
module busrel_hold_merge #(
  parameter int unsigned NUM_HOLD = 4
) (
  input  logic [NUM_HOLD-1:0] hold_vec,
  output logic                any_hold
);

  logic [NUM_HOLD:0] chain;

  assign chain[0] = 1'b0;

  generate
    for (genvar i = 0; i < NUM_HOLD; i++) begin : g_or
      assign chain[i+1] = chain[i] | hold_vec[i];
    end
  endgenerate

  assign any_hold = chain[NUM_HOLD];

endmodule

// File: rtl/busrel_rfsh_pend.sv
module busrel_rfsh_pend (
  input  logic clk,
  input  logic rst,
  input  logic req,
  input  logic take,
  output logic pend_any
);

  logic pend_q;

  // a request in the same clock as the decision counts immediately
  assign pend_any = pend_q | req;

  always_ff @(posedge clk) begin
    if (rst) pend_q <= 1'b0;
    else     pend_q <= pend_any & ~take;
  end

endmodule

// File: rtl/busrel_phase_timer.sv
module busrel_phase_timer #(
  parameter int unsigned PRE_CYC = 2,
  parameter int unsigned REF_CYC = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic load_pre,
  input  logic load_ref,
  output logic done
);

  localparam int unsigned MAX_CYC = (PRE_CYC > REF_CYC) ? PRE_CYC : REF_CYC;
  localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] PRE_LOAD = CNT_W'(PRE_CYC - 1);
  localparam logic [CNT_W-1:0] REF_LOAD = CNT_W'(REF_CYC - 1);

  logic [CNT_W-1:0] cnt_q;

  assign done = (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst)           cnt_q <= '0;
    else if (load_pre) cnt_q <= PRE_LOAD;
    else if (load_ref) cnt_q <= REF_LOAD;
    else if (!done)    cnt_q <= cnt_q - 1'b1;
  end

endmodule

// File: rtl/busrel_refresh_arb.sv
module busrel_refresh_arb
  import busrel_pkg::*;
#(
  parameter int unsigned PRE_CYC = 2,
  parameter int unsigned REF_CYC = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic ras_down,
  input  logic host_cyc,
  input  logic cyc_done,
  input  logic split_hold,
  input  logic burst_hold,
  input  logic atomic_hold,
  input  logic dual_hold,
  input  logic rfsh_req,
  input  logic ext_breq,
  output logic bus_ack,
  output logic rfsh_start,
  output logic pall_cmd
);

  arb_state_e state_q, state_d;
  logic       pre_rel_q, pre_rel_d;
  logic       any_hold, pend_any, tdone, at_bnd;
  logic       enter_pre, enter_ref;
  logic       ack_q, rfsh_q, pall_q;

  busrel_hold_merge #(.NUM_HOLD(NUM_HOLD)) u_hold (
    .hold_vec ({dual_hold, atomic_hold, burst_hold, split_hold}),
    .any_hold (any_hold)
  );

  busrel_rfsh_pend u_pend (
    .clk      (clk),
    .rst      (rst),
    .req      (rfsh_req),
    .take     (enter_ref),
    .pend_any (pend_any)
  );

  busrel_phase_timer #(.PRE_CYC(PRE_CYC), .REF_CYC(REF_CYC)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load_pre (enter_pre),
    .load_ref (enter_ref),
    .done     (tdone)
  );

  assign at_bnd = (state_q == ST_IDLE) || (state_q == ST_HOST && cyc_done);

  always_comb begin
    state_d   = state_q;
    pre_rel_d = pre_rel_q;
    unique case (state_q)
      ST_IDLE, ST_HOST: begin
        if (at_bnd) begin
          if (!any_hold && pend_any) begin
            state_d   = ras_down ? ST_PRECHG : ST_REFRESH;
            pre_rel_d = 1'b0;
          end else if (!any_hold && ext_breq) begin
            state_d   = ras_down ? ST_PRECHG : ST_RELEASED;
            pre_rel_d = 1'b1;
          end else if (host_cyc) begin
            state_d = ST_HOST;
          end else begin
            state_d = ST_IDLE;
          end
        end
      end
      ST_PRECHG: begin
        if (tdone) state_d = pre_rel_q ? ST_RELEASED : ST_REFRESH;
      end
      ST_REFRESH: begin
        if (tdone) state_d = ST_IDLE;
      end
      ST_RELEASED: begin
        if (!ext_breq)     state_d = ST_IDLE;
        else if (pend_any) state_d = ST_RECLAIM;
      end
      ST_RECLAIM: begin
        if (!ext_breq) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign enter_pre = (state_d == ST_PRECHG)  && (state_q != ST_PRECHG);
  assign enter_ref = (state_d == ST_REFRESH) && (state_q != ST_REFRESH);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      pre_rel_q <= 1'b0;
      ack_q     <= 1'b0;
      rfsh_q    <= 1'b0;
      pall_q    <= 1'b0;
    end else begin
      state_q   <= state_d;
      pre_rel_q <= pre_rel_d;
      ack_q     <= (state_d == ST_RELEASED);
      rfsh_q    <= enter_ref;
      pall_q    <= enter_pre;
    end
  end

  assign bus_ack    = ack_q;
  assign rfsh_start = rfsh_q;
  assign pall_cmd   = pall_q;

endmodule

// File: rtl/busrel_arb_chk.sv
module busrel_arb_chk (
  input logic clk,
  input logic rst,
  input logic ras_down,
  input logic split_hold,
  input logic burst_hold,
  input logic atomic_hold,
  input logic dual_hold,
  input logic ext_breq,
  input logic bus_ack,
  input logic rfsh_start,
  input logic pall_cmd
);

  logic free_now;
  assign free_now = !(split_hold || burst_hold || atomic_hold || dual_hold);

  // R1: refresh strobe lasts a single clock
  p_rfsh_pulse_r1: assert property (@(posedge clk) disable iff (rst)
    rfsh_start |=> !rfsh_start);

  // R3 (also R2, R4): direct refresh only after a boundary free of holds
  p_rfsh_free_r3: assert property (@(posedge clk) disable iff (rst)
    (rfsh_start && !ras_down && !$past(ras_down)) |-> $past(free_now));

  // R5: no refresh while the bus is lent out
  p_rfsh_not_lent_r5: assert property (@(posedge clk) disable iff (rst)
    rfsh_start |-> !bus_ack);

  // R6: precharge decided only at a free boundary
  p_pall_free_r6: assert property (@(posedge clk) disable iff (rst)
    pall_cmd |-> $past(free_now));

  // R6: strobes never overlap
  p_strobe_excl_r6: assert property (@(posedge clk) disable iff (rst)
    !(pall_cmd && rfsh_start));

  // R7: grant only follows an asserted request
  p_ack_needs_req_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_ack) |-> $past(ext_breq));

endmodule

bind busrel_refresh_arb busrel_arb_chk u_arb_chk (
  .clk         (clk),
  .rst         (rst),
  .ras_down    (ras_down),
  .split_hold  (split_hold),
  .burst_hold  (burst_hold),
  .atomic_hold (atomic_hold),
  .dual_hold   (dual_hold),
  .ext_breq    (ext_breq),
  .bus_ack     (bus_ack),
  .rfsh_start  (rfsh_start),
  .pall_cmd    (pall_cmd)
);

// File: tb/test_busrel_refresh_arb.sv
module test_busrel_refresh_arb;

  localparam int EV_ACK_UP = 0;
  localparam int EV_ACK_DN = 1;
  localparam int EV_PALL   = 2;
  localparam int EV_RFSH   = 3;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ras_down = 1'b0, host_cyc = 1'b0, cyc_done = 1'b0;
  logic [3:0] holds = 4'b0;
  logic       rfsh_req = 1'b0, ext_breq = 1'b0;
  logic       bus_ack, rfsh_start, pall_cmd;

  int n_run  = 0;
  int n_fail = 0;
  int cyc    = 0;
  bit ended  = 1'b0;

  typedef struct {
    int    kind;
    int    at;
    string req;
  } exp_t;
  exp_t exp_q[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  busrel_refresh_arb #(.PRE_CYC(3), .REF_CYC(2)) i_busrel_refresh_arb (
    .clk         (clk),
    .rst         (rst),
    .ras_down    (ras_down),
    .host_cyc    (host_cyc),
    .cyc_done    (cyc_done),
    .split_hold  (holds[0]),
    .burst_hold  (holds[1]),
    .atomic_hold (holds[2]),
    .dual_hold   (holds[3]),
    .rfsh_req    (rfsh_req),
    .ext_breq    (ext_breq),
    .bus_ack     (bus_ack),
    .rfsh_start  (rfsh_start),
    .pall_cmd    (pall_cmd)
  );

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0d, expected %0d", req, act, expv);
    end
  endtask

  task automatic expect_ev(input int kind, input int at, input string req);
    exp_t e;
    e.kind = kind;
    e.at   = at;
    e.req  = req;
    exp_q.push_back(e);
  endtask

  task automatic note_ev(input int kind);
    exp_t e;
    n_run++;
    if (exp_q.size() == 0) begin
      n_fail++;
      $display("FAIL unexpected: event %0d at cycle %0d, expected none", kind, cyc);
    end else begin
      e = exp_q.pop_front();
      if (e.kind != kind || e.at != cyc) begin
        n_fail++;
        $display("FAIL %s: event %0d at cycle %0d, expected event %0d at cycle %0d",
                 e.req, kind, cyc, e.kind, e.at);
      end
    end
  endtask

  // monitor: detect output edges and compare against the scoreboard
  logic ack_p = 1'b0, pall_p = 1'b0, rf_p = 1'b0;
  always @(negedge clk) begin
    if (!rst) begin
      if (bus_ack && !ack_p)   note_ev(EV_ACK_UP);
      if (!bus_ack && ack_p)   note_ev(EV_ACK_DN);
      if (pall_cmd && !pall_p) note_ev(EV_PALL);
      if (rfsh_start && !rf_p) note_ev(EV_RFSH);
    end
    ack_p  = bus_ack;
    pall_p = pall_cmd;
    rf_p   = rfsh_start;
  end

  task automatic idle(input int k);
    repeat (k) @(negedge clk);
  endtask

  // deferral across one kind of indivisible sequence
  task automatic hold_seq(input int which, input string req);
    @(negedge clk);
    host_cyc = 1'b1;
    holds[which] = 1'b1;
    idle(1);
    rfsh_req = 1'b1;
    idle(1);
    rfsh_req = 1'b0;
    for (int b = 0; b < 3; b++) begin
      idle(1);
      cyc_done = 1'b1;
      host_cyc = 1'b0;
      idle(1);
      cyc_done = 1'b0;
      idle(1);
      host_cyc = 1'b1;
      idle(1);
    end
    cyc_done = 1'b1;
    host_cyc = 1'b0;
    holds[which] = 1'b0;
    expect_ev(EV_RFSH, cyc + 1, req);
    idle(1);
    cyc_done = 1'b0;
    idle(6);
  endtask

  initial begin
    int t;
    idle(3);
    chk(bus_ack == 1'b0, "R10 ack", bus_ack, 0);
    chk(rfsh_start == 1'b0, "R10 rfsh", rfsh_start, 0);
    chk(pall_cmd == 1'b0, "R10 pall", pall_cmd, 0);
    rst = 1'b0;
    idle(3);

    // R1: refresh from idle at the next clock
    rfsh_req = 1'b1;
    expect_ev(EV_RFSH, cyc + 1, "R1");
    idle(1);
    rfsh_req = 1'b0;
    idle(6);

    // R9: several requests during a host cycle produce one refresh
    host_cyc = 1'b1;
    idle(2);
    for (int k = 0; k < 3; k++) begin
      rfsh_req = 1'b1;
      idle(1);
      rfsh_req = 1'b0;
      idle(1);
    end
    cyc_done = 1'b1;
    host_cyc = 1'b0;
    expect_ev(EV_RFSH, cyc + 1, "R9");
    idle(1);
    cyc_done = 1'b0;
    idle(10);

    hold_seq(0, "R2");
    hold_seq(1, "R3");
    hold_seq(2, "R4 atomic");
    hold_seq(3, "R4 dual");

    // R7: grant waits for the end of an atomic sequence
    host_cyc = 1'b1;
    holds[2] = 1'b1;
    ext_breq = 1'b1;
    idle(2);
    cyc_done = 1'b1;
    idle(1);
    cyc_done = 1'b0;
    idle(2);
    cyc_done = 1'b1;
    host_cyc = 1'b0;
    holds[2] = 1'b0;
    expect_ev(EV_ACK_UP, cyc + 1, "R7 grant");
    idle(1);
    cyc_done = 1'b0;
    idle(3);
    ext_breq = 1'b0;
    expect_ev(EV_ACK_DN, cyc + 1, "R7 return");
    idle(4);

    // R5: reclaim for a pending refresh
    ext_breq = 1'b1;
    expect_ev(EV_ACK_UP, cyc + 1, "R7");
    idle(3);
    rfsh_req = 1'b1;
    expect_ev(EV_ACK_DN, cyc + 1, "R5 reclaim");
    idle(1);
    rfsh_req = 1'b0;
    idle(4);
    ext_breq = 1'b0;
    expect_ev(EV_RFSH, cyc + 2, "R5 refresh");
    idle(8);

    // R8: refresh beats a simultaneous bus request
    rfsh_req = 1'b1;
    ext_breq = 1'b1;
    t = cyc;
    expect_ev(EV_RFSH, t + 1, "R8 refresh");
    expect_ev(EV_ACK_UP, t + 4, "R8 grant");
    idle(1);
    rfsh_req = 1'b0;
    idle(6);
    ext_breq = 1'b0;
    expect_ev(EV_ACK_DN, cyc + 1, "R8");
    idle(4);

    // R6: precharge before refresh and before hand-over
    ras_down = 1'b1;
    idle(1);
    rfsh_req = 1'b1;
    t = cyc;
    expect_ev(EV_PALL, t + 1, "R6 pall/refresh");
    expect_ev(EV_RFSH, t + 4, "R6 refresh");
    idle(1);
    rfsh_req = 1'b0;
    idle(8);
    ext_breq = 1'b1;
    t = cyc;
    expect_ev(EV_PALL, t + 1, "R6 pall/release");
    expect_ev(EV_ACK_UP, t + 4, "R6 grant");
    idle(6);
    ext_breq = 1'b0;
    expect_ev(EV_ACK_DN, cyc + 1, "R6");
    idle(3);
    ras_down = 1'b0;
    idle(10);

    chk(exp_q.size() == 0, "R1 all events seen", exp_q.size(), 0);
    if (!ended) begin
      ended = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!ended) begin
      ended = 1'b1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule